// File: doc/BRIEF.md
# Host Bus Front End for a Dot-Matrix Display Controller

This block sits between a host processor and the core of a dot-matrix display controller. Static strap pins choose one of three bus styles. The first is a parallel byte bus with separate active-low read and write strobes. The second is a parallel byte bus with an active-high enable strobe and a read/not-write line. The third is a write-only serial input, where bit 7 of the data pins carries the serial data and bit 6 carries the serial clock. A register-select line marks each transfer as display data or as command/status. Together with the direction of the transfer, this gives four kinds of access: command write, data write, status read and data read.

All host pins are asynchronous to the core clock. They pass through two-flop synchronizers, and every completed transfer reaches the core as a single-cycle pulse. A write gives a strobe, a tag that tells command from data, and the byte. A finished data read gives a pulse, so the core can move its read pipeline on. The block also drives one output-enable for the data pins. The core supplies the read byte and a busy flag.

Top module: `lcd_host_if`

## Requirements
- R1: The block is selected only while `cs_n` is 0 and `cs` is 1. In any other combination, strobes cause no write pulse and no read pulse, and `db_oe` stays 0.
- R2: In split-strobe mode (`par_sel`=1, `m68_sel`=0), a write runs while `strb_a` is 1 and `strb_b` is 0. On the rising edge of `strb_b` it ends with exactly one `core_wr` pulse. That pulse carries the byte present on `db_in` during the low phase, with `core_is_data` equal to `a0`.
- R3: In enable-strobe mode (`par_sel`=1, `m68_sel`=1), a write runs while `strb_a` is 1 and `strb_b` is 0. When `strb_a` falls, it ends with one `core_wr` pulse that carries the byte and the `a0` tag.
- R4: In split-strobe mode, `db_oe` is 1 while `strb_a` is 0 and the block is selected. With `a0`=1, `db_out` equals `core_rdata`. When such a data read ends, one `core_rd` pulse is given.
- R5: A read with `a0`=0 is a status read. `db_out` is {`core_busy`, 7'b0} and no `core_rd` pulse is given.
- R6: In enable-strobe mode, a read runs while `strb_a` is 1 and `strb_b` is 1. It drives `db_oe` and returns data in the same way as R4 and R5.
- R7: In serial mode (`par_sel`=0), `db_in[7]` is sampled on each rising edge of `db_in[6]`, MSB first. The eighth rising edge gives one `core_wr` pulse with the assembled byte, tagged with `a0` as sampled at that edge.
- R8: Deselecting the block in serial mode clears the bit counter and the shift register, so a partial byte is dropped and the next byte starts fresh.
- R9: In serial mode `db_oe` is never 1, whatever the strobe pins do.
- R10: `core_wr` and `core_rd` are single-cycle pulses that never coincide. After `rst_n` is released, both are 0 and `db_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 selects the parallel bus, 0 selects serial input |
| m68_sel | input | 1 | 1 selects enable-strobe style, 0 selects split strobes |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| a0 | input | 1 | 1 marks display data, 0 marks command/status |
| strb_a | input | 1 | Read strobe (active low) or enable (active high) |
| strb_b | input | 1 | Write strobe (active low) or read/not-write |
| db_in | input | 8 | Data pins as received; in serial mode bit 7 is data and bit 6 is clock |
| db_out | output | 8 | Read value driven toward the pins |
| db_oe | output | 1 | Output enable for all eight data pins |
| core_wr | output | 1 | One-cycle write strobe to the core |
| core_is_data | output | 1 | Tag of the write: 1 for data, 0 for command |
| core_wdata | output | 8 | Write byte |
| core_rd | output | 1 | One-cycle pulse when a data read ends |
| core_rdata | input | 8 | Display data supplied by the core |
| core_busy | input | 1 | Busy flag returned on status reads |

## Verification
Each bus style gets both command-tagged and data-tagged writes, with byte values whose bits differ from one another (0x3C, 0xC3, 0x81, 0x7E and others). These show whether the byte and the tag get through, and whether the bit order is kept. Reads are run both as data reads and as status reads, with the busy flag set both ways. This separates the `a0` path from the read-pulse path. In serial mode, a partial byte followed by a deselect tells a counter that is cleared apart from one that is not. Deselected strobes, and strobes given in serial mode, must produce nothing at the core and must never turn on the pin drivers.

// File: rtl/lcd_hif_pkg.sv
package lcd_hif_pkg;
  localparam int unsigned HIF_DATA_W = 8;
  // indices inside the synchronized pin vector
  localparam int unsigned PIN_PAR  = HIF_DATA_W + 6;
  localparam int unsigned PIN_M68  = HIF_DATA_W + 5;
  localparam int unsigned PIN_CSN  = HIF_DATA_W + 4;
  localparam int unsigned PIN_CS   = HIF_DATA_W + 3;
  localparam int unsigned PIN_A0   = HIF_DATA_W + 2;
  localparam int unsigned PIN_STA  = HIF_DATA_W + 1;
  localparam int unsigned PIN_STB  = HIF_DATA_W;
  localparam int unsigned PIN_W    = HIF_DATA_W + 7;

  typedef struct packed {
    logic                  is_data;
    logic [HIF_DATA_W-1:0] value;
  } hif_xfer_t;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int unsigned W      = 15,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hif_par.sv
module hif_par
  import lcd_hif_pkg::*;
#(
  parameter int unsigned DATA_W = HIF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              m68,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic              a0,
  input  logic [DATA_W-1:0] din,
  output logic              wr_pls,
  output logic              rd_pls,
  output logic              wr_is_data,
  output logic [DATA_W-1:0] wr_data,
  output logic              oe,
  output logic              rd_a0
);
  logic              rd_act, wr_act;
  logic              rd_q, wr_q;
  logic [DATA_W-1:0] hold_d_q, hold_d_d;
  logic              hold_a0_q, hold_a0_d;
  logic              wr_pls_d, rd_pls_d;
  logic [DATA_W-1:0] wr_data_d;
  logic              wr_isd_d;

  always_comb begin
    if (m68) begin
      rd_act = en & strb_a & strb_b;
      wr_act = en & strb_a & ~strb_b;
    end else begin
      rd_act = en & ~strb_a;
      wr_act = en & strb_a & ~strb_b;
    end
  end

  always_comb begin
    hold_d_d  = hold_d_q;
    hold_a0_d = hold_a0_q;
    if (wr_act) begin
      hold_d_d  = din;
      hold_a0_d = a0;
    end else if (rd_act) begin
      hold_a0_d = a0;
    end
    wr_pls_d  = wr_q & ~wr_act;
    rd_pls_d  = rd_q & ~rd_act & hold_a0_q;
    wr_data_d = wr_pls_d ? hold_d_q  : wr_data;
    wr_isd_d  = wr_pls_d ? hold_a0_q : wr_is_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      hold_d_q   <= '0;
      hold_a0_q  <= 1'b0;
      wr_pls     <= 1'b0;
      rd_pls     <= 1'b0;
      wr_data    <= '0;
      wr_is_data <= 1'b0;
    end else begin
      rd_q       <= rd_act;
      wr_q       <= wr_act;
      hold_d_q   <= hold_d_d;
      hold_a0_q  <= hold_a0_d;
      wr_pls     <= wr_pls_d;
      rd_pls     <= rd_pls_d;
      wr_data    <= wr_data_d;
      wr_is_data <= wr_isd_d;
    end
  end

  assign oe    = rd_q;
  assign rd_a0 = hold_a0_q;

  AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pls |=> !wr_pls); // R10
  AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pls |=> !rd_pls); // R10
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(en)); // R1
endmodule

// File: rtl/hif_ser.sv
module hif_ser
  import lcd_hif_pkg::*;
#(
  parameter int unsigned DATA_W = HIF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              a0,
  output logic              byte_vld,
  output logic              byte_is_data,
  output logic [DATA_W-1:0] byte_val
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              vld_d, isd_d;
  logic [DATA_W-1:0] val_d;
  logic              rise;

  assign rise = en & sclk & ~sclk_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    isd_d = byte_is_data;
    val_d = byte_val;
    if (!en) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (rise) begin
      sh_d  = {sh_q[DATA_W-2:0], sdi};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        vld_d = 1'b1;
        val_d = {sh_q[DATA_W-2:0], sdi};
        isd_d = a0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q       <= 1'b0;
      cnt_q        <= '0;
      sh_q         <= '0;
      byte_vld     <= 1'b0;
      byte_is_data <= 1'b0;
      byte_val     <= '0;
    end else begin
      sclk_q       <= sclk;
      cnt_q        <= cnt_d;
      sh_q         <= sh_d;
      byte_vld     <= vld_d;
      byte_is_data <= isd_d;
      byte_val     <= val_d;
    end
  end

  AST_SER_CLEAR_ON_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R8
  AST_SER_EIGHTH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> ($past(cnt_q) == CNT_LAST)); // R7
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_hif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  par_sel,
  input  logic                  m68_sel,
  input  logic                  cs_n,
  input  logic                  cs,
  input  logic                  a0,
  input  logic                  strb_a,
  input  logic                  strb_b,
  input  logic [HIF_DATA_W-1:0] db_in,
  output logic [HIF_DATA_W-1:0] db_out,
  output logic                  db_oe,
  output logic                  core_wr,
  output logic                  core_is_data,
  output logic [HIF_DATA_W-1:0] core_wdata,
  output logic                  core_rd,
  input  logic [HIF_DATA_W-1:0] core_rdata,
  input  logic                  core_busy
);
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CSN;

  logic [PIN_W-1:0] pin_s;
  logic             sel_s, par_en, ser_en;
  logic             par_wr, par_rd, par_isd, par_oe, par_a0;
  logic [HIF_DATA_W-1:0] par_data;
  logic             ser_vld, ser_isd;
  logic [HIF_DATA_W-1:0] ser_data;
  hif_xfer_t        wr_x;

  hif_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({par_sel, m68_sel, cs_n, cs, a0, strb_a, strb_b, db_in}),
    .q(pin_s)
  );

  assign sel_s  = ~pin_s[PIN_CSN] & pin_s[PIN_CS];
  assign par_en = sel_s &  pin_s[PIN_PAR];
  assign ser_en = sel_s & ~pin_s[PIN_PAR];

  hif_par #(.DATA_W(HIF_DATA_W)) i_par (
    .clk(clk), .rst_n(rst_n), .en(par_en), .m68(pin_s[PIN_M68]),
    .strb_a(pin_s[PIN_STA]), .strb_b(pin_s[PIN_STB]), .a0(pin_s[PIN_A0]),
    .din(pin_s[HIF_DATA_W-1:0]),
    .wr_pls(par_wr), .rd_pls(par_rd), .wr_is_data(par_isd), .wr_data(par_data),
    .oe(par_oe), .rd_a0(par_a0)
  );

  hif_ser #(.DATA_W(HIF_DATA_W)) i_ser (
    .clk(clk), .rst_n(rst_n), .en(ser_en),
    .sclk(pin_s[HIF_DATA_W-2]), .sdi(pin_s[HIF_DATA_W-1]), .a0(pin_s[PIN_A0]),
    .byte_vld(ser_vld), .byte_is_data(ser_isd), .byte_val(ser_data)
  );

  always_comb begin
    if (ser_vld) wr_x = '{is_data: ser_isd, value: ser_data};
    else         wr_x = '{is_data: par_isd, value: par_data};
  end

  assign core_wr      = par_wr | ser_vld;
  assign core_is_data = wr_x.is_data;
  assign core_wdata   = wr_x.value;
  assign core_rd      = par_rd;
  assign db_oe        = par_oe;
  assign db_out       = par_a0 ? core_rdata : {core_busy, {(HIF_DATA_W-1){1'b0}}};

  AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_wr && core_rd)); // R10
  AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_s[PIN_PAR] && $past(!pin_s[PIN_PAR])) |-> !db_oe); // R9
endmodule

// File: tb/test_lcd_host_if.sv
module test_lcd_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_sel = 1'b1, m68_sel = 1'b0, cs_n = 1'b1, cs = 1'b0, a0 = 1'b0;
  logic strb_a = 1'b1, strb_b = 1'b1;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out;
  logic db_oe, core_wr, core_is_data, core_rd;
  logic [7:0] core_wdata;
  logic [7:0] core_rdata = 8'h00;
  logic core_busy = 1'b0;

  int checks = 0, fails = 0, rd_seen = 0, rd_exp = 0;
  logic [8:0] expq [$];
  bit done = 0;

  always #5 clk = ~clk;

  lcd_host_if i_lcd_host_if (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .m68_sel(m68_sel),
    .cs_n(cs_n), .cs(cs), .a0(a0), .strb_a(strb_a), .strb_b(strb_b),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .core_wr(core_wr),
    .core_is_data(core_is_data), .core_wdata(core_wdata), .core_rd(core_rd),
    .core_rdata(core_rdata), .core_busy(core_busy)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected writes as pulses appear
  always @(negedge clk) begin
    if (rst_n && core_wr) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R1/R9 unexpected write", {7'd0, core_is_data, core_wdata}, 16'h0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({core_is_data, core_wdata} == e, "R2/R3/R7 write byte+tag",
            {7'd0, core_is_data, core_wdata}, {7'd0, e});
      end
    end
    if (rst_n && core_rd) rd_seen++;
  end

  task automatic w8080(input logic t, input logic [7:0] d, input bit expect_it);
    if (expect_it) expq.push_back({t, d});
    a0 = t; db_in = d; wt(3);
    strb_b = 1'b0; wt(4);
    strb_b = 1'b1; wt(5);
  endtask

  task automatic w6800(input logic t, input logic [7:0] d);
    expq.push_back({t, d});
    a0 = t; db_in = d; strb_b = 1'b0; wt(3);
    strb_a = 1'b1; wt(4);
    strb_a = 1'b0; wt(5);
  endtask

  task automatic ser_bits(input logic [7:0] d, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      db_in[7] = d[i]; db_in[6] = 1'b0; wt(3);
      db_in[6] = 1'b1; wt(3);
    end
    db_in[6] = 1'b0; wt(3);
  endtask

  task automatic ser_byte(input logic t, input logic [7:0] d);
    expq.push_back({t, d});
    a0 = t;
    ser_bits(d, 8);
    wt(3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    wt(3);
    rst_n = 1'b1;
    wt(4);
    chk(db_oe == 1'b0, "R10 reset oe", {15'd0, db_oe}, 16'd0);
    chk(core_wr == 1'b0 && core_rd == 1'b0, "R10 reset pulses", {14'd0, core_wr, core_rd}, 16'd0);

    // R1: deselected strobes do nothing
    w8080(1'b1, 8'h55, 1'b0);
    cs_n = 1'b0; cs = 1'b0; w8080(1'b0, 8'h66, 1'b0);
    cs_n = 1'b1; cs = 1'b1; a0 = 1'b1; strb_a = 1'b0; wt(6);
    chk(db_oe == 1'b0, "R1 deselected read oe", {15'd0, db_oe}, 16'd0);
    strb_a = 1'b1; wt(4);

    // R2: split-strobe writes
    cs_n = 1'b0; cs = 1'b1; wt(4);
    w8080(1'b0, 8'h3C, 1'b1);
    w8080(1'b1, 8'hC3, 1'b1);
    w8080(1'b1, 8'h81, 1'b1);

    // R4: data read
    core_rdata = 8'hA5; a0 = 1'b1; strb_a = 1'b0; wt(6);
    chk(db_oe == 1'b1, "R4 read oe", {15'd0, db_oe}, 16'd1);
    chk(db_out == 8'hA5, "R4 read data", {8'd0, db_out}, 16'h00A5);
    strb_a = 1'b1; rd_exp++; wt(6);
    chk(db_oe == 1'b0, "R4 oe released", {15'd0, db_oe}, 16'd0);
    chk(rd_seen == rd_exp, "R4 read pulse", rd_seen[15:0], rd_exp[15:0]);

    // R5: status read, busy both ways
    core_busy = 1'b1; a0 = 1'b0; strb_a = 1'b0; wt(6);
    chk(db_out == 8'h80, "R5 status busy", {8'd0, db_out}, 16'h0080);
    core_busy = 1'b0; wt(2);
    chk(db_out == 8'h00, "R5 status idle", {8'd0, db_out}, 16'h0000);
    strb_a = 1'b1; wt(6);
    chk(rd_seen == rd_exp, "R5 no read pulse", rd_seen[15:0], rd_exp[15:0]);

    // R3/R6: enable-strobe style
    m68_sel = 1'b1; strb_a = 1'b0; strb_b = 1'b1; wt(5);
    w6800(1'b1, 8'h7E);
    w6800(1'b0, 8'h01);
    core_rdata = 8'h5A; a0 = 1'b1; strb_b = 1'b1; wt(3);
    strb_a = 1'b1; wt(6);
    chk(db_oe == 1'b1 && db_out == 8'h5A, "R6 read data", {7'd0, db_oe, db_out}, 16'h015A);
    strb_a = 1'b0; rd_exp++; wt(6);
    chk(rd_seen == rd_exp, "R6 read pulse", rd_seen[15:0], rd_exp[15:0]);
    a0 = 1'b0; core_busy = 1'b1; strb_a = 1'b1; wt(6);
    chk(db_out == 8'h80 && db_oe, "R6 status read", {7'd0, db_oe, db_out}, 16'h0180);
    strb_a = 1'b0; core_busy = 1'b0; wt(6);
    chk(rd_seen == rd_exp, "R6 status no pulse", rd_seen[15:0], rd_exp[15:0]);

    // R7: serial mode
    m68_sel = 1'b0; strb_a = 1'b1; strb_b = 1'b1;
    cs_n = 1'b1; cs = 1'b0; par_sel = 1'b0; db_in = 8'h00; wt(5);
    cs_n = 1'b0; cs = 1'b1; wt(4);
    ser_byte(1'b1, 8'hB4);
    ser_byte(1'b0, 8'h2D);

    // R8: partial byte dropped on deselect
    a0 = 1'b1; ser_bits(8'hFF, 3);
    cs_n = 1'b1; wt(5);
    cs_n = 1'b0; wt(4);
    ser_byte(1'b1, 8'h96);

    // R9: strobes in serial mode never drive
    a0 = 1'b1; strb_a = 1'b0; wt(6);
    chk(db_oe == 1'b0, "R9 serial read attempt oe", {15'd0, db_oe}, 16'd0);
    strb_a = 1'b1; strb_b = 1'b0; wt(6);
    chk(db_oe == 1'b0, "R9 serial strobe oe", {15'd0, db_oe}, 16'd0);
    strb_b = 1'b1; wt(8);
    chk(rd_seen == rd_exp, "R9 no read pulse in serial", rd_seen[15:0], rd_exp[15:0]);

    wt(10);
    chk(expq.size() == 0, "R2/R3/R7 all writes seen", expq.size(), 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule